// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block is the datapath of a small 32-bit processor that takes several clock cycles per instruction. It runs word loads and stores, register-to-register arithmetic and logic, branch-if-equal and jump. One memory port carries both instruction fetches and data accesses. One ALU does every addition, subtraction and comparison, including the PC increment and the branch target. Values pass between steps through internal registers: the program counter, the instruction register, a memory data register, two operand registers and an ALU result register. The block also holds the 32-entry register file, the sign extender, the shift-by-two logic and every selection multiplexer.

The block makes no decisions of its own. An external step controller drives a set of discrete select and enable inputs each cycle. It reads the current instruction word from the `instr` output to pick the next step, and it uses the ALU zero flag to finish a branch. The memory sits outside the block. It returns read data combinationally for the address on `mem_addr`, and it takes a store's data from `mem_wdata` under its own write strobe.

Top module: `mc_datapath`

## Requirements
- R1: While `rst_n` is low, the program counter, instruction register, temporaries and register file all clear. After reset, with every control input low, `mem_addr` and `instr` read 0 and `alu_zero` reads 1.
- R2: A fetch step captures the memory word at PC into the instruction register and advances PC by 4 in the same edge. The fetch step sets `ir_load`=1, `pc_we`=1, `srca_sel`=0, `srcb_sel`=01, `alu_mode`=00 and `pc_src`=00.
- R3: The instruction register keeps its value whenever `ir_load` is low. Every other temporary register loads on every edge.
- R4: `mem_addr` is PC when `addr_sel`=0 and the ALU result register when `addr_sel`=1. `mem_wdata` is always the B operand register.
- R5: The second ALU operand is chosen by `srcb_sel`: 00 selects B, 01 selects the constant 4, 10 selects the sign-extended low 16 bits of the instruction, and 11 selects that value shifted left by 2. A load or store address is base register plus the sign-extended offset. A load writes register field [20:16] when `dst_sel`=0 and `wb_sel`=1.
- R6: With `alu_mode`=10, the function field [5:0] selects the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than. The result is written to register field [15:11] when `dst_sel`=1 and `wb_sel`=0. `alu_mode` 00 adds and 01 subtracts.
- R7: Register 0 always reads as zero, and writes to it have no effect.
- R8: The decode step leaves PC+4 plus the shifted offset in the ALU result register. PC then loads that value (`pc_src`=01) only when `pc_cond_we` is high and `alu_zero` is 1. PC holds whenever neither PC write enable applies.
- R9: With `pc_src`=10 and `pc_we` high, PC becomes PC[31:28] followed by instruction bits [25:0] and two zero bits.
- R10: `alu_zero` is high exactly when the combinational ALU result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_rdata | input | 32 | Memory read data for `mem_addr` |
| pc_we | input | 1 | Unconditional PC write |
| pc_cond_we | input | 1 | PC write qualified by ALU zero |
| addr_sel | input | 1 | Memory address select: 0 PC, 1 ALU result register |
| ir_load | input | 1 | Instruction register load enable |
| dst_sel | input | 1 | Write register select: 0 field [20:16], 1 field [15:11] |
| wb_sel | input | 1 | Write data select: 0 ALU result register, 1 memory data register |
| rf_we | input | 1 | Register file write enable |
| srca_sel | input | 1 | ALU operand A select: 0 PC, 1 A register |
| srcb_sel | input | 2 | ALU operand B select |
| alu_mode | input | 2 | 00 add, 01 subtract, 10 function field |
| pc_src | input | 2 | Next PC: 00 ALU result, 01 ALU result register, 10 jump address |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Store data |
| instr | output | 32 | Current instruction register contents |
| alu_zero | output | 1 | ALU result equals zero |

## Verification
The assertions assume the control inputs arrive as legal step patterns. The PC-increment check fires only on the exact fetch pattern. The not-taken-branch and hold checks assume `pc_we` stays low whenever `pc_cond_we` is meant to decide alone. `pc_src`=11 is never used. The bench plays the role of the step controller. It issues only the fetch, decode, execute, memory and write-back patterns that each instruction class calls for. It changes them on the falling edge, so every pattern is settled before the rising edge that acts on it.

// File: rtl/mc_datapath.sv
module mc_datapath (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] mem_rdata,
  input  logic        pc_we,
  input  logic        pc_cond_we,
  input  logic        addr_sel,
  input  logic        ir_load,
  input  logic        dst_sel,
  input  logic        wb_sel,
  input  logic        rf_we,
  input  logic        srca_sel,
  input  logic [1:0]  srcb_sel,
  input  logic [1:0]  alu_mode,
  input  logic [1:0]  pc_src,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [31:0] instr,
  output logic        alu_zero
);

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {OP_ADD, OP_SUB, OP_AND, OP_OR, OP_SLT} alu_op_e;

  logic [31:0] pc, ir, mdr, a_q, b_q, alu_out;
  logic [31:0] rf [32];
  logic [31:0] op_a, op_b, alu_res, pc_next;
  alu_op_e     alu_op;

  wire [4:0]  rs_idx   = ir[25:21];
  wire [4:0]  rt_idx   = ir[20:16];
  wire [4:0]  wr_idx   = dst_sel ? ir[15:11] : rt_idx;
  wire [31:0] wr_data  = wb_sel ? mdr : alu_out;
  wire [31:0] imm_ext  = {{16{ir[15]}}, ir[15:0]};
  wire [31:0] jump_tgt = {pc[31:28], ir[25:0], 2'b00};
  wire        pc_load  = pc_we | (pc_cond_we & alu_zero);

  assign op_a      = srca_sel ? a_q : pc;
  assign mem_addr  = addr_sel ? alu_out : pc;
  assign mem_wdata = b_q;
  assign instr     = ir;
  assign alu_zero  = (alu_res == 32'd0);

  always_comb begin
    case (srcb_sel)
      2'b00:   op_b = b_q;
      2'b01:   op_b = 32'd4;
      2'b10:   op_b = imm_ext;
      default: op_b = {imm_ext[29:0], 2'b00};
    endcase
  end

  always_comb begin
    case (alu_mode)
      2'b01: alu_op = OP_SUB;
      2'b10: begin
        case (ir[5:0])
          FN_SUB:  alu_op = OP_SUB;
          FN_AND:  alu_op = OP_AND;
          FN_OR:   alu_op = OP_OR;
          FN_SLT:  alu_op = OP_SLT;
          FN_ADD:  alu_op = OP_ADD;
          default: alu_op = OP_ADD;
        endcase
      end
      default: alu_op = OP_ADD;
    endcase
  end

  always_comb begin
    case (alu_op)
      OP_SUB:  alu_res = op_a - op_b;
      OP_AND:  alu_res = op_a & op_b;
      OP_OR:   alu_res = op_a | op_b;
      OP_SLT:  alu_res = {31'd0, $signed(op_a) < $signed(op_b)};
      default: alu_res = op_a + op_b;
    endcase
  end

  always_comb begin
    case (pc_src)
      2'b01:   pc_next = alu_out;
      2'b10:   pc_next = jump_tgt;
      default: pc_next = alu_res;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc      <= '0;
      ir      <= '0;
      mdr     <= '0;
      a_q     <= '0;
      b_q     <= '0;
      alu_out <= '0;
    end else begin
      if (pc_load) pc <= pc_next;
      if (ir_load) ir <= mem_rdata;
      mdr     <= mem_rdata;
      a_q     <= rf[rs_idx];
      b_q     <= rf[rt_idx];
      alu_out <= alu_res;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) rf[i] <= '0;
    end else if (rf_we && wr_idx != 5'd0) begin
      rf[wr_idx] <= wr_data;
    end
  end

  // R2
  pc_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we && !srca_sel && srcb_sel == 2'b01 && alu_mode == 2'b00 && pc_src == 2'b00)
    |=> pc == $past(pc) + 32'd4);

  // R3
  ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_load |=> $stable(ir));

  // R8
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_we && !pc_cond_we) |=> $stable(pc));

  // R8
  branch_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_we && pc_cond_we && !alu_zero) |=> $stable(pc));

  // R9
  jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we && pc_src == 2'b10)
    |=> pc == {$past(pc[31:28]), $past(ir[25:0]), 2'b00});

  // R7
  reg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && wr_idx == 5'd0) |=> rf[0] == 32'd0);

endmodule

// File: tb/mc_datapath_bench.sv
module mc_datapath_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mem_rdata;
  logic        pc_we, pc_cond_we, addr_sel, ir_load, dst_sel, wb_sel, rf_we, srca_sel;
  logic [1:0]  srcb_sel, alu_mode, pc_src;
  logic [31:0] mem_addr, mem_wdata, instr;
  logic        alu_zero;
  logic        mem_we;

  logic [31:0] mem [0:255];
  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  mc_datapath u_mc_datapath (
    .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata),
    .pc_we(pc_we), .pc_cond_we(pc_cond_we), .addr_sel(addr_sel),
    .ir_load(ir_load), .dst_sel(dst_sel), .wb_sel(wb_sel), .rf_we(rf_we),
    .srca_sel(srca_sel), .srcb_sel(srcb_sel), .alu_mode(alu_mode), .pc_src(pc_src),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .instr(instr), .alu_zero(alu_zero)
  );

  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;

  function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt,
                                        input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] enc_j(input logic [25:0] idx);
    return {6'h02, idx};
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ctl_idle();
    pc_we = 0; pc_cond_we = 0; addr_sel = 0; ir_load = 0; dst_sel = 0; wb_sel = 0;
    rf_we = 0; srca_sel = 0; srcb_sel = 2'b00; alu_mode = 2'b00; pc_src = 2'b00; mem_we = 0;
  endtask

  task automatic clr_mem();
    for (int i = 0; i < 256; i++) mem[i] = 32'd0;
  endtask

  task automatic do_reset();
    ctl_idle();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic fetch_decode();
    ctl_idle(); ir_load = 1; pc_we = 1; srcb_sel = 2'b01;
    @(negedge clk);
    ctl_idle(); srcb_sel = 2'b11;
    @(negedge clk);
    ctl_idle();
  endtask

  task automatic run_one();
    fetch_decode();
    case (instr[31:26])
      6'h23, 6'h2B: begin
        srca_sel = 1; srcb_sel = 2'b10;
        @(negedge clk);
        ctl_idle(); addr_sel = 1;
        if (instr[31:26] == 6'h2B) mem_we = 1;
        @(negedge clk);
        ctl_idle();
        if (instr[31:26] == 6'h23) begin
          wb_sel = 1; rf_we = 1;
          @(negedge clk);
          ctl_idle();
        end
      end
      6'h00: begin
        srca_sel = 1; alu_mode = 2'b10;
        @(negedge clk);
        ctl_idle(); dst_sel = 1; rf_we = 1;
        @(negedge clk);
        ctl_idle();
      end
      6'h04: begin
        srca_sel = 1; alu_mode = 2'b01; pc_cond_we = 1; pc_src = 2'b01;
        @(negedge clk);
        ctl_idle();
      end
      6'h02: begin
        pc_we = 1; pc_src = 2'b10;
        @(negedge clk);
        ctl_idle();
      end
      default: @(negedge clk);
    endcase
  endtask

  task automatic check_pc(input logic [31:0] exp, input string tag);
    ctl_idle();
    #1;
    check(mem_addr, exp, tag);
  endtask

  task automatic t_reset();
    clr_mem();
    do_reset();
    #1;
    check(mem_addr, 32'd0, "R1 pc after reset");
    check(instr, 32'd0, "R1 ir after reset");
    check({31'd0, alu_zero}, 32'd1, "R10 zero flag on 0+0");
  endtask

  task automatic t_fetch();
    clr_mem();
    mem[0] = enc_i(6'h23, 5'd0, 5'd1, 16'h0100);
    mem[1] = 32'h1111_2222;
    do_reset();
    ctl_idle(); ir_load = 1; pc_we = 1; srcb_sel = 2'b01;
    @(negedge clk);
    ctl_idle();
    #1;
    check(instr, mem[0], "R2 fetched word");
    check(mem_addr, 32'd4, "R2 pc plus 4");
    @(negedge clk);
    addr_sel = 1;
    repeat (3) @(negedge clk);
    ctl_idle();
    #1;
    check(instr, enc_i(6'h23, 5'd0, 5'd1, 16'h0100), "R3 ir held");
  endtask

  task automatic t_loadstore();
    clr_mem();
    mem[0] = enc_i(6'h23, 5'd0, 5'd1, 16'h0100);
    mem[1] = enc_i(6'h23, 5'd1, 5'd2, 16'hFFFC);
    mem[2] = enc_i(6'h2B, 5'd1, 5'd2, 16'h0010);
    mem[64] = 32'h0000_0108;
    mem[65] = 32'hCAFE_F00D;
    do_reset();
    for (int i = 0; i < 3; i++) run_one();
    check(mem[70], 32'hCAFE_F00D, "R4 R5 store of loaded word");
    check_pc(32'd12, "R2 pc after three instructions");
  endtask

  task automatic t_alu();
    logic [31:0] exp [7];
    clr_mem();
    mem[0]  = enc_i(6'h23, 5'd0, 5'd1, 16'h0100);
    mem[1]  = enc_i(6'h23, 5'd0, 5'd2, 16'h0104);
    mem[2]  = enc_r(5'd1, 5'd2, 5'd3, 6'h20);
    mem[3]  = enc_r(5'd1, 5'd2, 5'd4, 6'h22);
    mem[4]  = enc_r(5'd1, 5'd2, 5'd5, 6'h24);
    mem[5]  = enc_r(5'd1, 5'd2, 5'd6, 6'h25);
    mem[6]  = enc_r(5'd2, 5'd1, 5'd7, 6'h2A);
    mem[7]  = enc_r(5'd1, 5'd2, 5'd8, 6'h2A);
    mem[8]  = enc_r(5'd1, 5'd1, 5'd0, 6'h20);
    for (int i = 0; i < 6; i++)
      mem[9 + i] = enc_i(6'h2B, 5'd0, 5'(3 + i), 16'(16'h0120 + 16'(4 * i)));
    mem[15] = enc_i(6'h2B, 5'd0, 5'd0, 16'h0138);
    mem[64] = 32'd7;
    mem[65] = 32'hFFFF_FFFD;
    mem[78] = 32'hDEAD_BEEF;
    do_reset();
    for (int i = 0; i < 16; i++) run_one();
    exp[0] = 32'd4; exp[1] = 32'd10; exp[2] = 32'd5; exp[3] = 32'hFFFF_FFFF;
    exp[4] = 32'd1; exp[5] = 32'd0; exp[6] = 32'd0;
    check(mem[72], exp[0], "R6 add");
    check(mem[73], exp[1], "R6 sub");
    check(mem[74], exp[2], "R6 and");
    check(mem[75], exp[3], "R6 or");
    check(mem[76], exp[4], "R6 slt signed true");
    check(mem[77], exp[5], "R6 slt false");
    check(mem[78], exp[6], "R7 register zero after write");
  endtask

  task automatic t_branch();
    clr_mem();
    mem[0] = enc_i(6'h23, 5'd0, 5'd1, 16'h0100);
    mem[1] = enc_i(6'h23, 5'd0, 5'd2, 16'h0104);
    mem[2] = enc_i(6'h04, 5'd1, 5'd2, 16'h0002);
    mem[5] = enc_i(6'h04, 5'd1, 5'd0, 16'h0005);
    mem[6] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFFD);
    mem[4] = enc_j(26'h30);
    mem[64] = 32'd5;
    mem[65] = 32'd5;
    do_reset();
    run_one(); run_one(); run_one();
    check_pc(32'd20, "R8 taken forward branch");
    run_one();
    check_pc(32'd24, "R8 branch not taken");
    run_one();
    check_pc(32'd16, "R8 taken backward branch");
    run_one();
    check_pc(32'h0000_00C0, "R9 jump target");
  endtask

  task automatic t_zero();
    clr_mem();
    mem[0] = enc_i(6'h23, 5'd0, 5'd1, 16'h0100);
    mem[1] = enc_i(6'h23, 5'd0, 5'd2, 16'h0104);
    mem[2] = enc_i(6'h23, 5'd0, 5'd3, 16'h0108);
    mem[3] = enc_i(6'h04, 5'd1, 5'd3, 16'h0001);
    mem[4] = enc_i(6'h04, 5'd1, 5'd2, 16'h0001);
    mem[64] = 32'd5; mem[65] = 32'd5; mem[66] = 32'd9;
    do_reset();
    for (int i = 0; i < 3; i++) run_one();
    fetch_decode();
    srca_sel = 1; alu_mode = 2'b01; pc_cond_we = 1; pc_src = 2'b01;
    #1;
    check({31'd0, alu_zero}, 32'd0, "R10 zero low on unequal");
    @(negedge clk);
    check_pc(32'd16, "R8 unequal keeps pc");
    fetch_decode();
    srca_sel = 1; alu_mode = 2'b01; pc_cond_we = 1; pc_src = 2'b01;
    #1;
    check({31'd0, alu_zero}, 32'd1, "R10 zero high on equal");
    @(negedge clk);
    check_pc(32'd24, "R8 equal takes branch");
  endtask

  initial begin
    ctl_idle();
    t_reset();
    t_fetch();
    t_loadstore();
    t_alu();
    t_branch();
    t_zero();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule